// File: doc/BRIEF.md
# DMA Request Sense and Bus Handoff Controller

This block decides, one byte at a time, whether a single DMA channel or the CPU drives the bus. An active-low request pin is synchronised and read either as a level or as a falling edge. A mode input selects which. The request is read once per byte, at a fixed point near the end of the write cycle. What it shows there decides whether the channel runs another byte or hands the bus back to the CPU.

Each DMA byte is a read machine cycle followed by a write machine cycle. Each machine cycle runs T1, T2, any number of wait states and T3. A loadable byte counter sets how many bytes the channel moves. When the counter reads zero, the byte in progress is the last one, and a transfer-end output is driven low for the whole of that byte. Once the last byte completes, the channel turns itself off.

Top module: `dma_req_handoff`

## Requirements
- R1: After reset the CPU owns the bus (`dma_own` = 0), `tstate` = 0, `rd_n`, `wr_n` and `tend_n` are all high, the channel is off and no request edge is pending.
- R2: A DMA byte steps through read T1, T2, Tw*, T3 and then write T1, T2, Tw*, T3. After T2 or a Tw, the next state is Tw while `wait_req` is high and T3 otherwise. `tstate` encodes 0 = CPU owns the bus, 1 = T1, 2 = T2, 3 = T3, 4 = Tw. A byte with W wait states per machine cycle therefore lasts 6+2W cycles.
- R3: `rd_n` is low in T2, Tw and T3 of the read cycle. `wr_n` is low in T2, Tw and T3 of the write cycle. The two are never low together.
- R4: In level mode (`edge_mode` = 0), an enabled channel takes the bus while the synchronised request is low. If the request stays low, the bytes follow each other with no CPU cycle between them.
- R5: The request is read at the rising edge that ends the cycle just before write T3. That cycle is write T2 when there are no waits, otherwise the last Tw. In level mode, a request seen high at that point returns the bus to the CPU after the current byte.
- R6: In edge mode (`edge_mode` = 1), an enabled channel takes the bus on a falling edge of `dreq_n`.
- R7: In edge mode, another byte follows only if a fresh falling edge has arrived since the previous decision. Otherwise the CPU gets the bus after the current byte and keeps it until a new falling edge arrives, even if `dreq_n` stays low.
- R8: Loading count K gives K+1 bytes. The count drops by one at the end of every byte. After the byte run with count zero, the channel turns off and the bus returns to the CPU whatever the request shows.
- R9: `tend_n` is low for every cycle of the byte run while the count reads zero, and high at all other times.
- R10: `cnt_load` and `chan_start` are ignored while the DMA owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_n | input | 1 | Asynchronous active-low DMA request |
| wait_req | input | 1 | High inserts a wait state after T2 or Tw |
| edge_mode | input | 1 | 0 = level-sensed request, 1 = falling-edge-sensed request |
| chan_start | input | 1 | One-cycle pulse that turns the channel on |
| cnt_load | input | 1 | One-cycle pulse that loads `cnt_val` into the byte counter |
| cnt_val | input | CNT_W | Byte count to load (K gives K+1 bytes) |
| dma_own | output | 1 | High while the DMA owns the bus |
| tstate | output | 3 | Current T-state (0 CPU, 1 T1, 2 T2, 3 T3, 4 Tw) |
| rd_n | output | 1 | Active-low read strobe of the DMA read cycle |
| wr_n | output | 1 | Active-low write strobe of the DMA write cycle |
| tend_n | output | 1 | Active-low transfer end, low during the last byte |

## Verification
Level mode is swept over every count from 0 to 3 and every wait count from 0 to 2 with the request held low. This separates the byte-length arithmetic, the byte count and the self-disable from the request logic. Releasing the request during the read T1 of a byte and during its write T1 locates the sampling point: the late release still yields one extra byte with no waits, but none when waits are present. In edge mode, the bench compares a single edge with the request held low against a fresh pulse in every byte, which tells consumption of the sticky edge apart from level sensing. A count reload and a channel start issued in the middle of a burst show that the busy guard holds.

// File: rtl/dhs_pkg.sv
package dhs_pkg;

    typedef enum logic [3:0] {
        ST_CPU,
        ST_RT1, ST_RT2, ST_RTW, ST_RT3,
        ST_WT1, ST_WT2, ST_WTW, ST_WT3
    } bus_st_e;

    localparam logic [2:0] TS_NONE = 3'd0;
    localparam logic [2:0] TS_T1   = 3'd1;
    localparam logic [2:0] TS_T2   = 3'd2;
    localparam logic [2:0] TS_T3   = 3'd3;
    localparam logic [2:0] TS_TW   = 3'd4;

endpackage

// File: rtl/dhs_req_sense.sv
module dhs_req_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq_n,
    input  logic edge_mode,
    input  logic consume,
    output logic req_lvl,
    output logic req_edge_ok
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
        logic                   flag;
    } sense_t;

    sense_t s_d, s_q;
    logic   edge_now;

    always_comb begin
        s_d      = s_q;
        req_lvl  = s_q.sync[SYNC_STAGES-1];
        edge_now = req_lvl & ~s_q.prev;
        s_d.sync = {s_q.sync[SYNC_STAGES-2:0], ~dreq_n};
        s_d.prev = req_lvl;
        // an edge landing in the consuming cycle is used by that decision
        s_d.flag = edge_mode & ~consume & (s_q.flag | edge_now);
        req_edge_ok = s_q.flag | edge_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.sync <= '1;
            s_q.prev <= 1'b1;
            s_q.flag <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/dhs_bus_seq.sv
module dhs_bus_seq
    import dhs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    chan_on,
    input  logic    req_ok,
    input  logic    wait_req,
    input  logic    last_byte,
    output bus_st_e state,
    output logic    consume,
    output logic    byte_done
);
    typedef struct packed {
        bus_st_e st;
        logic    cont;
    } seq_t;

    seq_t q_d, q_q;

    always_comb begin
        q_d       = q_q;
        consume   = 1'b0;
        byte_done = 1'b0;
        unique case (q_q.st)
            ST_CPU: begin
                if (chan_on && req_ok) begin
                    q_d.st  = ST_RT1;
                    consume = 1'b1;
                end
            end
            ST_RT1: q_d.st = ST_RT2;
            ST_RT2, ST_RTW: q_d.st = wait_req ? ST_RTW : ST_RT3;
            ST_RT3: q_d.st = ST_WT1;
            ST_WT1: q_d.st = ST_WT2;
            ST_WT2, ST_WTW: begin
                if (wait_req) begin
                    q_d.st = ST_WTW;
                end else begin
                    q_d.st   = ST_WT3;
                    q_d.cont = req_ok;
                    consume  = 1'b1;
                end
            end
            ST_WT3: begin
                byte_done = 1'b1;
                q_d.st    = (last_byte || !q_q.cont) ? ST_CPU : ST_RT1;
                q_d.cont  = 1'b0;
            end
            default: q_d.st = ST_CPU;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q.st   <= ST_CPU;
            q_q.cont <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign state = q_q.st;

endmodule

// File: rtl/dhs_byte_ctr.sv
module dhs_byte_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             start,
    input  logic             byte_done,
    output logic [CNT_W-1:0] cnt,
    output logic             chan_on,
    output logic             last
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             on;
    } ctr_t;

    ctr_t c_d, c_q;

    always_comb begin
        c_d  = c_q;
        last = (c_q.cnt == '0);
        if (!busy) begin
            if (load)  c_d.cnt = load_val;
            if (start) c_d.on  = 1'b1;
        end
        if (byte_done) begin
            if (last) c_d.on  = 1'b0;
            else      c_d.cnt = c_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cnt <= '0;
            c_q.on  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt     = c_q.cnt;
    assign chan_on = c_q.on;

endmodule

// File: rtl/dma_req_handoff.sv
module dma_req_handoff
    import dhs_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dreq_n,
    input  logic             wait_req,
    input  logic             edge_mode,
    input  logic             chan_start,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_val,
    output logic             dma_own,
    output logic [2:0]       tstate,
    output logic             rd_n,
    output logic             wr_n,
    output logic             tend_n
);
    bus_st_e          st;
    logic             req_lvl, req_edge_ok, req_ok;
    logic             consume, byte_done;
    logic             chan_on, last_byte;
    logic [CNT_W-1:0] byte_cnt;

    dhs_req_sense #(.SYNC_STAGES(SYNC_STAGES)) sense_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dreq_n      (dreq_n),
        .edge_mode   (edge_mode),
        .consume     (consume),
        .req_lvl     (req_lvl),
        .req_edge_ok (req_edge_ok)
    );

    assign req_ok = edge_mode ? req_edge_ok : req_lvl;

    dhs_bus_seq seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_on   (chan_on),
        .req_ok    (req_ok),
        .wait_req  (wait_req),
        .last_byte (last_byte),
        .state     (st),
        .consume   (consume),
        .byte_done (byte_done)
    );

    dhs_byte_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (dma_own),
        .load      (cnt_load),
        .load_val  (cnt_val),
        .start     (chan_start),
        .byte_done (byte_done),
        .cnt       (byte_cnt),
        .chan_on   (chan_on),
        .last      (last_byte)
    );

    always_comb begin
        dma_own = (st != ST_CPU);
        rd_n    = 1'b1;
        wr_n    = 1'b1;
        unique case (st)
            ST_RT1, ST_WT1: tstate = TS_T1;
            ST_RT2, ST_WT2: tstate = TS_T2;
            ST_RTW, ST_WTW: tstate = TS_TW;
            ST_RT3, ST_WT3: tstate = TS_T3;
            default:        tstate = TS_NONE;
        endcase
        if (st inside {ST_RT2, ST_RTW, ST_RT3}) rd_n = 1'b0;
        if (st inside {ST_WT2, ST_WTW, ST_WT3}) wr_n = 1'b0;
        tend_n = ~(dma_own & last_byte);
    end

endmodule

// File: rtl/dhs_chk.sv
module dhs_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wait_req,
    input logic             dma_own,
    input logic [2:0]       tstate,
    input logic             rd_n,
    input logic             wr_n,
    input logic             tend_n,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             byte_done
);
    // R2
    t1_then_t2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tstate == 3'd1 |=> tstate == 3'd2);
    // R2
    wait_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == 3'd2 || tstate == 3'd4) && wait_req) |=> tstate == 3'd4);
    // R2
    wait_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tstate == 3'd2 || tstate == 3'd4) && !wait_req) |=> tstate == 3'd3);
    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    // R5
    release_after_t3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_own) |-> $past(tstate) == 3'd3);
    // R9
    tend_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tend_n |-> dma_own);
    // R8
    last_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && byte_cnt == '0) |=> !dma_own);
    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_own && !byte_done) |=> $stable(byte_cnt));

endmodule

bind dma_req_handoff dhs_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wait_req  (wait_req),
    .dma_own   (dma_own),
    .tstate    (tstate),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .tend_n    (tend_n),
    .byte_cnt  (byte_cnt),
    .byte_done (byte_done)
);

// File: tb/dma_req_handoff_tb.sv
module dma_req_handoff_tb_top;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dreq_n = 1'b1;
    logic             wait_req = 1'b0;
    logic             edge_mode = 1'b0;
    logic             chan_start = 1'b0;
    logic             cnt_load = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic             dma_own;
    logic [2:0]       tstate;
    logic             rd_n, wr_n, tend_n;

    dma_req_handoff #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .wait_req(wait_req),
        .edge_mode(edge_mode), .chan_start(chan_start), .cnt_load(cnt_load),
        .cnt_val(cnt_val), .dma_own(dma_own), .tstate(tstate), .rd_n(rd_n),
        .wr_n(wr_n), .tend_n(tend_n)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    int own_cyc, wr_cyc, tend_cyc, bursts, t1_cnt;
    int wsel, wcnt, release_at;
    bit prev_own, pulse_en, pulse_pend;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // monitor, wait generator, release and pulse drivers
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
        if (dma_own) own_cyc++;
        if (!wr_n) wr_cyc++;
        if (!tend_n) tend_cyc++;
        if (dma_own && !prev_own) bursts++;
        prev_own = dma_own;
        if (tstate == 3'd1) begin
            t1_cnt++;
            wcnt = 0;
            if (release_at != 0 && t1_cnt == release_at) dreq_n = 1'b1;
        end
        if ((tstate == 3'd2 || tstate == 3'd4) && wcnt < wsel) begin
            wait_req = 1'b1;
            wcnt++;
        end else begin
            wait_req = 1'b0;
        end
        if (pulse_pend) begin
            dreq_n = 1'b0;
            pulse_pend = 1'b0;
        end else if (pulse_en && tstate == 3'd1 && (t1_cnt % 2) == 1) begin
            dreq_n = 1'b1;
            pulse_pend = 1'b1;
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        chan_start = 1'b0;
        cnt_load = 1'b0;
        pulse_en = 1'b0;
        pulse_pend = 1'b0;
        release_at = 0;
        run(3);
        own_cyc = 0; wr_cyc = 0; tend_cyc = 0; bursts = 0; t1_cnt = 0;
        rst_n = 1'b1;
        run(1);
    endtask

    task automatic load_and_start(input int k);
        @(negedge clk);
        cnt_load = 1'b1;
        cnt_val = CNT_W'(k);
        chan_start = 1'b1;
        @(negedge clk);
        cnt_load = 1'b0;
        chan_start = 1'b0;
    endtask

    initial begin
        int b;
        wsel = 0; wcnt = 0; release_at = 0;
        own_cyc = 0; wr_cyc = 0; tend_cyc = 0; bursts = 0; t1_cnt = 0;
        prev_own = 0; pulse_en = 0; pulse_pend = 0;
        run(2);
        // R1 reset state, checked while reset is held
        chk(dma_own == 1'b0, "R1 dma_own", dma_own, 0);
        chk(tstate == 3'd0, "R1 tstate", tstate, 0);
        chk(rd_n && wr_n, "R1 strobes", {rd_n, wr_n}, 3);
        chk(tend_n == 1'b1, "R1 tend_n", tend_n, 1);

        // R2 R3 R4 R8 R9: level sweep with request held low
        for (int w = 0; w <= 2; w++) begin
            for (int k = 0; k <= 3; k++) begin
                b = 6 + 2 * w;
                wsel = w;
                edge_mode = 1'b0;
                dreq_n = 1'b1;
                do_reset();
                dreq_n = 1'b0;
                load_and_start(k);
                run((k + 1) * b + 30);
                chk(own_cyc == (k + 1) * b, "R2/R8 owned cycles", own_cyc, (k + 1) * b);
                chk(wr_cyc == (k + 1) * (2 + w), "R3 write strobe cycles", wr_cyc, (k + 1) * (2 + w));
                chk(tend_cyc == b, "R9 tend cycles", tend_cyc, b);
                chk(bursts == 1, "R4 single burst", bursts, 1);
                chk(dma_own == 1'b0, "R8 disabled with request low", dma_own, 0);
            end
        end

        // R10: reload and restart in the middle of a burst are ignored
        wsel = 0; edge_mode = 1'b0; dreq_n = 1'b1;
        do_reset();
        dreq_n = 1'b0;
        load_and_start(3);
        run(5);
        cnt_load = 1'b1; cnt_val = '0; chan_start = 1'b1;
        run(1);
        cnt_load = 1'b0; chan_start = 1'b0;
        run(4 * 6 + 30);
        chk(own_cyc == 24, "R10 busy load ignored", own_cyc, 24);
        chk(tend_cyc == 6, "R10 tend after ignored load", tend_cyc, 6);

        // R5: release in read T1 vs write T1 of the second byte
        for (int w = 0; w <= 2; w++) begin
            b = 6 + 2 * w;
            wsel = w; edge_mode = 1'b0; dreq_n = 1'b1;
            do_reset();
            release_at = 3;
            dreq_n = 1'b0;
            load_and_start(3);
            run(4 * b + 30);
            chk(own_cyc == 2 * b, "R5 release in read T1", own_cyc, 2 * b);
            release_at = 0;
            dreq_n = 1'b0;
            run(4 * b + 30);
            chk(own_cyc == 4 * b, "R5 resume total", own_cyc, 4 * b);
            chk(bursts == 2, "R5 two bursts", bursts, 2);

            do_reset();
            release_at = 4;
            dreq_n = 1'b0;
            load_and_start(3);
            run(4 * b + 30);
            chk(own_cyc == ((w == 0) ? 3 : 2) * b, "R5 release in write T1",
                own_cyc, ((w == 0) ? 3 : 2) * b);
            release_at = 0;
            dreq_n = 1'b1;
        end

        // R6 R7: edge mode, single edge with request held low
        for (int w = 0; w <= 2; w++) begin
            b = 6 + 2 * w;
            wsel = w; edge_mode = 1'b1; dreq_n = 1'b1;
            do_reset();
            load_and_start(3);
            run(5);
            chk(own_cyc == 0, "R6 no start without edge", own_cyc, 0);
            dreq_n = 1'b0;
            run(b + 20);
            chk(own_cyc == b, "R6/R7 one byte per edge", own_cyc, b);
            run(40);
            chk(own_cyc == b, "R7 CPU keeps bus while low", own_cyc, b);
            dreq_n = 1'b1;
            run(4);
            dreq_n = 1'b0;
            run(b + 20);
            chk(own_cyc == 2 * b, "R7 new edge gives byte", own_cyc, 2 * b);
            chk(bursts == 2, "R7 two bursts", bursts, 2);
            chk(tend_cyc == 0, "R9 tend high before last", tend_cyc, 0);
        end

        // R7: a fresh edge in every byte keeps the channel running
        for (int w = 0; w <= 2; w++) begin
            b = 6 + 2 * w;
            wsel = w; edge_mode = 1'b1; dreq_n = 1'b1;
            do_reset();
            load_and_start(3);
            run(4);
            pulse_en = 1'b1;
            dreq_n = 1'b0;
            run(4 * b + 30);
            pulse_en = 1'b0;
            chk(own_cyc == 4 * b, "R7 continuous with edges", own_cyc, 4 * b);
            chk(bursts == 1, "R7 single burst", bursts, 1);
            chk(tend_cyc == b, "R9 tend last byte", tend_cyc, b);
        end

        finish_run();
    end

endmodule